// File: doc/BRIEF.md
# Asynchronous Parallel Flash Bus Controller

This block is the host side of a 16-bit asynchronous parallel flash array made of two banks, each 128K words deep. A client issues one transfer at a time on a synchronous valid/ready port. A transfer carries an 18-bit word address, 16 bits of write data and a write flag. The controller then runs the pin-level read or write cycle. It drives two active-low bank selects, an active-low output enable, an active-low write enable and a 17-bit address. The data bus is split into an outgoing value, a tri-state drive enable and an incoming value. It signals completion with a one-clock response pulse that carries read data.

Every interval of the flash timing is a parameter counted in system clocks. The integrator rounds each one up from nanoseconds for the speed grade and clock in use. A write opens with an address-setup phase, then holds the write-enable low pulse, then a data-hold phase, then a write-enable-high recovery phase. The address is held from the first phase to the end of the last. The flash takes the address at the falling edge of write enable and the data at the rising edge. A read holds both select and output enable low for an access count. It samples the data in the last clock of that count. It then waits a float count with the bus released before it reports.

Top module: `flash_bus_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, req_ready_o is 1, rsp_valid_o is 0, both bank selects are high, fl_oe_n_o and fl_we_n_o are high, and fl_dq_oe_o is 0.
- R2: Request address bit 17 picks the bank. When it is 0, fl_ce_n_o reads 2'b10 (bit 0 low). When it is 1, fl_ce_n_o reads 2'b01 (bit 1 low). The value 2'b00 never appears.
- R3: When a transfer completes, both selects are high in the response cycle. As a result, an access to one bank is never followed by an access to the other bank without at least one clock with fl_ce_n_o = 2'b11.
- R4: A write counts clocks from the first clock after acceptance. The select is low with write enable high for T_AS clocks. Write enable is then low for T_WP clocks. Write enable is then high with the select still low for T_DH + T_WPH clocks. Output enable stays high for the whole write and in the clock before write enable falls.
- R5: fl_dq_oe_o is 1 only during the T_WP write-enable-low clocks and the T_DH clocks after them. While it is 1, fl_dq_o equals the accepted write data.
- R6: While a select is low, fl_addr_o equals bits 16:0 of the accepted address and does not change.
- R7: A read holds the select and output enable low, with write enable high and no bus drive, for T_ACC clocks from the first clock after acceptance. The value on fl_dq_i in the last of those clocks is returned on rsp_rdata_o.
- R8: After a read's output enable rises, the controller waits T_DF clocks before it completes. During that wait both selects and output enable are high and the bus is not driven.
- R9: req_ready_o is 0 from the clock after acceptance until the response. rsp_valid_o is high for exactly one clock, and req_ready_o returns to 1 in that same clock. A write completes T_AS+T_WP+T_DH+T_WPH clocks after acceptance and a read completes T_ACC+T_DF clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address, bit 17 selects the bank |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 16 | Data returned by the last read |
| fl_ce_n_o | output | 2 | Active-low bank selects, bit 0 lower bank |
| fl_oe_n_o | output | 1 | Active-low output enable |
| fl_we_n_o | output | 1 | Active-low write enable |
| fl_addr_o | output | 17 | Flash address |
| fl_dq_o | output | 16 | Data driven toward the flash |
| fl_dq_oe_o | output | 1 | Tri-state drive enable for fl_dq_o |
| fl_dq_i | input | 16 | Data read from the flash |

## Verification
Two things can happen in the same clock: the completion of one transfer and the acceptance of the next, which may target the other bank. The bench raises a new request in the very clock that the response pulse appears. It alternates bank bit 17 between back-to-back transfers to provoke this. It judges the result in three ways. A continuous pin monitor flags any 2'b00 on the selects and any direct switch from one bank to the other. Every transfer's trace must show both selects high in the response clock. Reads after cross-bank writes must return the values the bench's own shadow memory predicts.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WSET = 3'd1,
    ST_WLOW = 3'd2,
    ST_WHLD = 3'd3,
    ST_WREC = 3'd4,
    ST_RACC = 3'd5,
    ST_RFLT = 3'd6
  } fl_state_e;
endpackage

// File: rtl/flash_phase_tmr.sv
module flash_phase_tmr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_bank_dec.sv
module flash_bank_dec #(
  parameter int unsigned BANKS = 2,
  localparam int unsigned BW   = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [BW-1:0]    bank_i,
  output logic [BANKS-1:0] ce_n_o
);
  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign ce_n_o[b] = !(active_i && (bank_i == BW'(b)));
  end

  assert_cs_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~ce_n_o) <= 1);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_bus_pkg::*;
#(
  parameter int unsigned T_AS  = 2,
  parameter int unsigned T_WP  = 3,
  parameter int unsigned T_DH  = 1,
  parameter int unsigned T_WPH = 2,
  parameter int unsigned T_ACC = 5,
  parameter int unsigned T_DF  = 2,
  parameter int unsigned CW    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wr_i,
  output logic idle_o,
  output logic done_o,
  output logic cap_o,
  output logic cs_act_o,
  output logic oe_act_o,
  output logic we_act_o,
  output logic drive_o
);
  fl_state_e     state_q, state_d;
  logic          ld, zero, done_d, done_q;
  logic [CW-1:0] ld_val;

  flash_phase_tmr #(.CW(CW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(ld),
    .val_i (ld_val),
    .zero_o(zero)
  );

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ld_val  = '0;
    done_d  = 1'b0;
    cap_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ld = 1'b1;
        if (wr_i) begin state_d = ST_WSET; ld_val = CW'(T_AS - 1);  end
        else      begin state_d = ST_RACC; ld_val = CW'(T_ACC - 1); end
      end
      ST_WSET: if (zero) begin state_d = ST_WLOW; ld = 1'b1; ld_val = CW'(T_WP - 1);  end
      ST_WLOW: if (zero) begin state_d = ST_WHLD; ld = 1'b1; ld_val = CW'(T_DH - 1);  end
      ST_WHLD: if (zero) begin state_d = ST_WREC; ld = 1'b1; ld_val = CW'(T_WPH - 1); end
      ST_WREC: if (zero) begin state_d = ST_IDLE; done_d = 1'b1; end
      ST_RACC: if (zero) begin
        state_d = ST_RFLT; ld = 1'b1; ld_val = CW'(T_DF - 1); cap_o = 1'b1;
      end
      ST_RFLT: if (zero) begin state_d = ST_IDLE; done_d = 1'b1; end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign done_o   = done_q;
  assign cs_act_o = (state_q inside {ST_WSET, ST_WLOW, ST_WHLD, ST_WREC, ST_RACC});
  assign oe_act_o = (state_q == ST_RACC);
  assign we_act_o = (state_q == ST_WLOW);
  assign drive_o  = (state_q inside {ST_WLOW, ST_WHLD});

  assert_rsp_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned FL_AW  = 17,
  parameter int unsigned DW     = 16,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 3,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WPH  = 2,
  parameter int unsigned T_ACC  = 5,
  parameter int unsigned T_DF   = 2,
  parameter int unsigned CW     = 8,
  localparam int unsigned BW    = ADDR_W - FL_AW,
  localparam int unsigned BANKS = 1 << BW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DW-1:0]     rsp_rdata_o,
  output logic [BANKS-1:0]  fl_ce_n_o,
  output logic              fl_oe_n_o,
  output logic              fl_we_n_o,
  output logic [FL_AW-1:0]  fl_addr_o,
  output logic [DW-1:0]     fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [DW-1:0]     fl_dq_i
);
  logic              start, idle, cap, cs_act, oe_act, we_act, drive;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q, rdata_q;
  logic              we_q;

  assign start = req_valid_i && idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        we_q    <= req_we_i;
      end
      if (cap) rdata_q <= fl_dq_i;
    end
  end

  flash_seq #(
    .T_AS(T_AS), .T_WP(T_WP), .T_DH(T_DH), .T_WPH(T_WPH),
    .T_ACC(T_ACC), .T_DF(T_DF), .CW(CW)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .wr_i    (req_we_i),
    .idle_o  (idle),
    .done_o  (rsp_valid_o),
    .cap_o   (cap),
    .cs_act_o(cs_act),
    .oe_act_o(oe_act),
    .we_act_o(we_act),
    .drive_o (drive)
  );

  flash_bank_dec #(.BANKS(BANKS)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(cs_act),
    .bank_i  (addr_q[ADDR_W-1:FL_AW]),
    .ce_n_o  (fl_ce_n_o)
  );

  assign req_ready_o = idle;
  assign rsp_rdata_o = rdata_q;
  assign fl_oe_n_o   = !oe_act;
  assign fl_we_n_o   = !we_act;
  assign fl_addr_o   = addr_q[FL_AW-1:0];
  assign fl_dq_o     = wdata_q;
  assign fl_dq_oe_o  = drive;

  // never hand the selects straight from one bank to another
  assert_bank_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(fl_ce_n_o) != '1) && (fl_ce_n_o != '1)) |-> (fl_ce_n_o == $past(fl_ce_n_o)));

  assert_rd_recovery_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_we_n_o) |-> (fl_oe_n_o && $past(fl_oe_n_o)));

  assert_dq_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_dq_oe_o |-> (fl_oe_n_o && (fl_ce_n_o != '1) && $stable(fl_dq_o)));

  assert_addr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fl_ce_n_o != '1) && ($past(fl_ce_n_o) != '1)) |-> $stable(fl_addr_o));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: tb/flash_bus_ctrl_tb.sv
module flash_bus_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_AS = 2, T_WP = 3, T_DH = 1, T_WPH = 2, T_ACC = 5, T_DF = 2;
  localparam int WR_LEN = T_AS + T_WP + T_DH + T_WPH;
  localparam int RD_LEN = T_ACC + T_DF;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [1:0]  fl_ce_n;
  logic        fl_oe_n, fl_we_n, fl_dq_oe;
  logic [16:0] fl_addr;
  logic [15:0] fl_dq_o, fl_dq_i;

  int checks = 0, errors = 0, bad_excl = 0, bad_gap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_ctrl #(.T_AS(T_AS), .T_WP(T_WP), .T_DH(T_DH), .T_WPH(T_WPH),
                   .T_ACC(T_ACC), .T_DF(T_DF)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .fl_ce_n_o(fl_ce_n), .fl_oe_n_o(fl_oe_n), .fl_we_n_o(fl_we_n),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  // flash model: 16 words per bank, keyed by {bank, addr[3:0]}
  logic [15:0] fmem   [0:31];
  logic [15:0] shadow [0:31];
  logic        prev_we = 1'b1, wbank = 1'b0;
  logic [3:0]  waddr = '0;
  logic [1:0]  prev_ce = 2'b11;

  function automatic logic [15:0] init_val(int i);
    return 16'hA500 ^ 16'(i * 16'h0111);
  endfunction

  function automatic int key_of(logic [17:0] a);
    return int'({a[17], a[3:0]});
  endfunction

  function automatic logic [1:0] exp_ce(logic [17:0] a);
    return a[17] ? 2'b01 : 2'b10;
  endfunction

  always_comb begin
    fl_dq_i = 16'hBAD0;
    if (!fl_oe_n) begin
      if (!fl_ce_n[0])      fl_dq_i = fmem[{1'b0, fl_addr[3:0]}];
      else if (!fl_ce_n[1]) fl_dq_i = fmem[{1'b1, fl_addr[3:0]}];
    end
  end

  always @(negedge clk) begin
    if (prev_we && !fl_we_n) begin
      waddr = fl_addr[3:0];
      wbank = !fl_ce_n[1];
    end
    if (!prev_we && fl_we_n) fmem[{wbank, waddr}] = fl_dq_o;
    prev_we = fl_we_n;
    if (rst_n) begin
      if (fl_ce_n == 2'b00) bad_excl++;
      if (prev_ce != 2'b11 && fl_ce_n != 2'b11 && fl_ce_n != prev_ce) bad_gap++;
    end
    prev_ce = fl_ce_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  logic [1:0]  tr_ce   [0:63];
  logic        tr_oe   [0:63], tr_we [0:63], tr_dqoe [0:63], tr_rdy [0:63], tr_rsp [0:63];
  logic [15:0] tr_dq   [0:63];
  logic [16:0] tr_addr [0:63];

  // called at a negedge with the controller idle
  task automatic do_req(input bit we, input logic [17:0] a, input logic [15:0] d);
    int len;
    bit ok2, ok3, ok4, ok5, ok6, ok7, ok8, ok9;
    logic [15:0] rd;
    len = we ? WR_LEN : RD_LEN;
    chk(req_ready == 1'b1, "R9", "ready before request", 32'(req_ready), 1);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= len; i++) begin
      tr_ce[i] = fl_ce_n; tr_oe[i] = fl_oe_n; tr_we[i] = fl_we_n; tr_dqoe[i] = fl_dq_oe;
      tr_dq[i] = fl_dq_o; tr_addr[i] = fl_addr; tr_rdy[i] = req_ready; tr_rsp[i] = rsp_valid;
      if (i == len) rd = rsp_rdata;
      else @(negedge clk);
    end
    ok2 = 1; ok4 = 1; ok5 = 1; ok6 = 1; ok7 = 1; ok8 = 1; ok9 = 1;
    for (int i = 0; i < len; i++) begin
      ok9 &= (tr_rdy[i] == 1'b0) && (tr_rsp[i] == 1'b0);
      if (we) begin
        bit wl, drv;
        wl  = (i >= T_AS) && (i < T_AS + T_WP);
        drv = (i >= T_AS) && (i < T_AS + T_WP + T_DH);
        ok2 &= (tr_ce[i] == exp_ce(a));
        ok4 &= (tr_oe[i] == 1'b1) && (tr_we[i] == !wl);
        ok5 &= (tr_dqoe[i] == drv) && (!drv || tr_dq[i] == d);
        ok6 &= (tr_addr[i] == a[16:0]);
      end else if (i < T_ACC) begin
        ok2 &= (tr_ce[i] == exp_ce(a));
        ok7 &= (tr_oe[i] == 1'b0) && (tr_we[i] == 1'b1) && (tr_dqoe[i] == 1'b0);
        ok6 &= (tr_addr[i] == a[16:0]);
      end else begin
        ok8 &= (tr_ce[i] == 2'b11) && (tr_oe[i] == 1'b1) && (tr_dqoe[i] == 1'b0);
      end
    end
    ok9 &= (tr_rdy[len] == 1'b1) && (tr_rsp[len] == 1'b1);
    ok3 = (tr_ce[len] == 2'b11) && tr_oe[len] && tr_we[len] && !tr_dqoe[len];
    chk(ok2, "R2", "bank select", 32'(tr_ce[0]), 32'(exp_ce(a)));
    chk(ok3, "R3", "selects high at completion", 32'(tr_ce[len]), 32'h3);
    chk(ok6, "R6", "address held", 32'(tr_addr[0]), 32'(a[16:0]));
    chk(ok9, "R9", "handshake timing", 32'(tr_rsp[len]), 1);
    if (we) begin
      chk(ok4, "R4", "write strobe pattern", 32'(tr_we[T_AS]), 0);
      chk(ok5, "R5", "data drive window", 32'(tr_dq[T_AS]), 32'(d));
      shadow[key_of(a)] = d;
    end else begin
      chk(ok7, "R7", "read strobe pattern", 32'(tr_oe[0]), 0);
      chk(ok8, "R8", "float wait", 32'(tr_oe[T_ACC]), 1);
      chk(rd == shadow[key_of(a)], "R7", "read data", 32'(rd), 32'(shadow[key_of(a)]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      fmem[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state, during reset
    chk(req_ready && !rsp_valid && fl_ce_n == 2'b11 && fl_oe_n && fl_we_n && !fl_dq_oe,
        "R1", "outputs in reset", {26'd0, req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n},
        32'h2F);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && fl_ce_n == 2'b11 && fl_oe_n && fl_we_n && !fl_dq_oe,
        "R1", "outputs after reset", {26'd0, req_ready, rsp_valid, fl_ce_n, fl_oe_n, fl_we_n},
        32'h2F);

    // directed: untouched location, same slot in both banks, top address
    do_req(1'b0, 18'h00009, 16'h0);
    do_req(1'b1, 18'h00005, 16'h1111);
    do_req(1'b1, 18'h20005, 16'h2222);
    do_req(1'b0, 18'h00005, 16'h0);
    do_req(1'b0, 18'h20005, 16'h0);
    do_req(1'b1, 18'h3FFFF, 16'hFFFF);
    do_req(1'b0, 18'h3FFFF, 16'h0);
    do_req(1'b1, 18'h00000, 16'h0000);
    // back-to-back bank alternation (R3)
    for (int i = 0; i < 8; i++)
      do_req(i[0], {i[1], 13'h0ABC, i[3:0]}, 16'(16'h5A00 + i));
    // random traffic
    for (int i = 0; i < 60; i++)
      do_req(1'($urandom % 2), 18'($urandom), 16'($urandom));
    // idle gap then read back every slot
    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++)
      do_req(1'b0, {i[4], 13'h1234, i[3:0]}, 16'h0);

    chk(bad_excl == 0, "R2", "both selects low seen", 32'(bad_excl), 0);
    chk(bad_gap == 0, "R3", "direct bank switch seen", 32'(bad_gap), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule